// File: doc/BRIEF.md
# Conversion Mode Sequencer

This block is the control state machine behind a delta-sigma converter. Each write carries a 3-bit mode code, a 4-bit rate code, a chop-disable flag and a channel number. The block then holds the digital filter in reset, starts conversions, powers the converter down or runs a calibration. It times every conversion by dividing the 1.024 MHz system clock with a programmable down-counter. The count comes from a per-rate table and is doubled for the first result after a start while chop is enabled.

Toward the register interface the block gives a one-cycle result strobe, an active-low ready line that a read acknowledge clears, and offset or gain write strobes tagged with the channel that a calibration served. It also decodes a 2-bit clock-source field into the enables for the internal oscillator, the clock pin driver and the external clock select. The parameter `DIV_SHIFT` shortens every period by a right shift, so a test can run with short periods. Its default of 0 keeps the real cycle counts.

Top module: `conv_seq`

## Requirements
- R1: Mode codes are 000 continuous, 001 single, 010 idle, 011 sleep, 100 internal zero-scale cal, 101 internal full-scale cal, 110 system zero-scale cal, 111 system full-scale cal. In continuous mode, after the first result, `result_stb` pulses once every P cycles, and `conv_start` pulses at the start of every conversion.
- R2: P for each rate code is its full count shifted right by DIV_SHIFT, with a minimum of 1. The full counts are: 0000:1151, 0001:2179, 0010:4231, 0011:8325, 0100:16516, 0101:20480, 0110:26256, 0111:30843, 1000:52245, 1001:61440, 1010:61440, 1011:81920, 1100:102400, 1101:122880, 1110:163840, 1111:245760.
- R3: Let W be the clock edge that samples `cfg_wr`. The first result after a write comes at edge W+2P when `cfg_chop_off` is 0, and at edge W+P when it is 1. Later results take P.
- R4: In idle, `filt_rst` is 1, `mod_run` is 1, `pwr_down` is 0, and no result or calibration strobe appears.
- R5: In sleep, `pwr_down` is 1, `mod_run` is 0, `filt_rst` is 1, and no strobe appears.
- R6: Single mode wakes from idle or sleep and produces exactly one result. It then enters sleep with `rdy_n` held low.
- R7: While a calibration runs, `cal_busy` and `rdy_n` are 1. The calibration ends after the same time as a first conversion. At its end the block pulses `cal_wr_ofs` for zero-scale codes or `cal_wr_gain` for full-scale codes, with `cal_chan` equal to the channel latched at the write. `rdy_n` then goes low and the block is left in idle.
- R8: `cal_system` is 1 only during a system calibration (codes 110 and 111).
- R9: A write during a conversion aborts that conversion, with no result for it, and restarts timing in the new mode.
- R10: `rdy_n` goes low with each result and returns high on the edge after `rd_ack` or after a new write.
- R11: Clock source 00 gives `osc_en`=1, `clk_pin_oe`=0, `ext_clk_sel`=0. Source 01 gives 1, 1, 0. Source 1x gives 0, 0, 1. The outputs follow the input one cycle later.
- R12: Reset leaves `filt_rst`=1, `rdy_n`=1 and no strobe, then runs continuous mode at rate 1010 with chop on. The first result comes 2P edges after reset is released.
- R13: Every write that starts a conversion or a calibration raises `filt_rst` and `conv_start` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.024 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Mode write strobe; samples the cfg_* fields below |
| cfg_mode | input | 3 | Mode code |
| cfg_rate | input | 4 | Rate code |
| cfg_chop_off | input | 1 | 1 disables chop |
| cfg_chan | input | CH_W | Selected channel |
| cfg_clk_src | input | 2 | Clock-source selection |
| rd_ack | input | 1 | Result read acknowledge |
| filt_rst | output | 1 | Digital filter reset |
| conv_start | output | 1 | Conversion start pulse |
| mod_run | output | 1 | Modulator enable |
| pwr_down | output | 1 | Sleep/power-down control |
| result_stb | output | 1 | New result pulse |
| rdy_n | output | 1 | Active-low ready line |
| cal_busy | output | 1 | Calibration in progress |
| cal_system | output | 1 | System (not internal) calibration |
| cal_wr_ofs | output | 1 | Store offset coefficient pulse |
| cal_wr_gain | output | 1 | Store gain coefficient pulse |
| cal_chan | output | CH_W | Channel whose coefficient is stored |
| osc_en | output | 1 | Internal oscillator enable |
| clk_pin_oe | output | 1 | Drive internal clock onto clock pin |
| ext_clk_sel | output | 1 | Use external clock from pin |

## Verification
The bench times the first result under both chop settings. A design that skips the doubled settling, or applies it to every result, misses the expected strobe cycle. It writes a new mode in the middle of a conversion: a sequencer that lets the old count finish produces a stray result, which the empty scoreboard rejects. Calibrations are checked for the store strobe, its channel tag and the fall back to idle. A swapped offset/gain decode or a missing idle entry shows as a wrong strobe or as conversions that keep running. A sweep over all sixteen rate codes catches a wrong entry in the period table.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [2:0] {
    M_CONT   = 3'b000,
    M_SINGLE = 3'b001,
    M_IDLE   = 3'b010,
    M_SLEEP  = 3'b011,
    M_CAL_IZ = 3'b100,
    M_CAL_IF = 3'b101,
    M_CAL_SZ = 3'b110,
    M_CAL_SF = 3'b111
  } mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2
  } seq_state_e;

  localparam int unsigned MAX_FULL_CYC = 245760;
  localparam int          CNT_W        = $clog2(2 * MAX_FULL_CYC + 1);
  localparam logic [3:0]  RATE_RST     = 4'b1010;

  // System clock cycles per conversion period at 1.024 MHz
  function automatic int unsigned full_cycles(input logic [3:0] code);
    case (code)
      4'h0:    return 1151;
      4'h1:    return 2179;
      4'h2:    return 4231;
      4'h3:    return 8325;
      4'h4:    return 16516;
      4'h5:    return 20480;
      4'h6:    return 26256;
      4'h7:    return 30843;
      4'h8:    return 52245;
      4'h9:    return 61440;
      4'hA:    return 61440;
      4'hB:    return 81920;
      4'hC:    return 102400;
      4'hD:    return 122880;
      4'hE:    return 163840;
      default: return 245760;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] period_cycles(input logic [3:0] code,
                                                     input int unsigned shift);
    int unsigned v;
    v = full_cycles(code) >> shift;
    if (v == 0) v = 1;
    return CNT_W'(v);
  endfunction

endpackage

// File: rtl/conv_period_div.sv
module conv_period_div
  import conv_seq_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         at_zero
);

  logic [W-1:0] cnt;

  // The controller asserts load throughout reset, so the load path initialises cnt.
  always_ff @(posedge clk) begin
    if (load)             cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign at_zero = (cnt == '0);

  AST_DIV_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R2

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> (cnt == '0)); // R2

endmodule

// File: rtl/conv_clk_route.sv
module conv_clk_route (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src,
  output logic       osc_en,
  output logic       pin_oe,
  output logic       ext_sel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_en  <= 1'b1;
      pin_oe  <= 1'b0;
      ext_sel <= 1'b0;
    end else begin
      osc_en  <= ~src[1];
      pin_oe  <= (src == 2'b01);
      ext_sel <= src[1];
    end
  end

  AST_PIN_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
    pin_oe |-> osc_en); // R11

  AST_EXT_EXCL: assert property (@(posedge clk) disable iff (rst)
    ext_sel |-> !osc_en); // R11

endmodule

// File: rtl/conv_mode_ctrl.sv
module conv_mode_ctrl
  import conv_seq_pkg::*;
#(
  parameter int unsigned DIV_SHIFT = 0,
  parameter int          CH_W      = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_mode,
  input  logic [3:0]      cfg_rate,
  input  logic            cfg_chop_off,
  input  logic [CH_W-1:0] cfg_chan,
  input  logic            rd_ack,
  input  logic            cnt_zero,
  output logic            div_load,
  output logic [CNT_W-1:0] div_val,
  output logic            filt_rst,
  output logic            conv_start,
  output logic            mod_run,
  output logic            pwr_down,
  output logic            result_stb,
  output logic            rdy_n,
  output logic            cal_busy,
  output logic            cal_system,
  output logic            cal_wr_ofs,
  output logic            cal_wr_gain,
  output logic [CH_W-1:0] cal_chan
);

  seq_state_e        state;
  mode_e             run_mode;
  logic [3:0]        rate_q;
  logic [CH_W-1:0]   chan_q;

  logic [CNT_W-1:0]  per_new, per_cur, per_rst;
  logic              new_is_conv;

  assign per_new     = period_cycles(cfg_rate, DIV_SHIFT);
  assign per_cur     = period_cycles(rate_q, DIV_SHIFT);
  assign per_rst     = period_cycles(RATE_RST, DIV_SHIFT);
  assign new_is_conv = !(cfg_mode == M_IDLE || cfg_mode == M_SLEEP);
  assign cal_chan    = chan_q;

  // Period counter reload
  always_comb begin
    div_load = 1'b0;
    div_val  = per_cur - 1'b1;
    if (rst) begin
      div_load = 1'b1;
      div_val  = (per_rst << 1) - 1'b1;
    end else if (cfg_wr) begin
      div_load = new_is_conv;
      div_val  = cfg_chop_off ? per_new - 1'b1 : (per_new << 1) - 1'b1;
    end else if (state == ST_RUN && cnt_zero && run_mode == M_CONT) begin
      div_load = 1'b1;
      div_val  = per_cur - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    conv_start  <= 1'b0;
    result_stb  <= 1'b0;
    cal_wr_ofs  <= 1'b0;
    cal_wr_gain <= 1'b0;
    if (rst) begin
      state      <= ST_RUN;
      run_mode   <= M_CONT;
      rate_q     <= RATE_RST;
      chan_q     <= '0;
      filt_rst   <= 1'b1;
      mod_run    <= 1'b1;
      pwr_down   <= 1'b0;
      rdy_n      <= 1'b1;
      cal_busy   <= 1'b0;
      cal_system <= 1'b0;
    end else if (cfg_wr) begin
      run_mode <= mode_e'(cfg_mode);
      rate_q   <= cfg_rate;
      chan_q   <= cfg_chan;
      rdy_n    <= 1'b1;
      filt_rst <= 1'b1;
      case (mode_e'(cfg_mode))
        M_IDLE: begin
          state      <= ST_IDLE;
          mod_run    <= 1'b1;
          pwr_down   <= 1'b0;
          cal_busy   <= 1'b0;
          cal_system <= 1'b0;
        end
        M_SLEEP: begin
          state      <= ST_SLEEP;
          mod_run    <= 1'b0;
          pwr_down   <= 1'b1;
          cal_busy   <= 1'b0;
          cal_system <= 1'b0;
        end
        default: begin
          state      <= ST_RUN;
          conv_start <= 1'b1;
          mod_run    <= 1'b1;
          pwr_down   <= 1'b0;
          cal_busy   <= cfg_mode[2];
          cal_system <= cfg_mode[2] & cfg_mode[1];
        end
      endcase
    end else begin
      if (rd_ack) rdy_n <= 1'b1;
      if (state == ST_RUN) begin
        filt_rst <= 1'b0;
        if (cnt_zero) begin
          case (run_mode)
            M_CONT: begin
              result_stb <= 1'b1;
              rdy_n      <= 1'b0;
              conv_start <= 1'b1;
            end
            M_SINGLE: begin
              result_stb <= 1'b1;
              rdy_n      <= 1'b0;
              state      <= ST_SLEEP;
              pwr_down   <= 1'b1;
              mod_run    <= 1'b0;
              filt_rst   <= 1'b1;
            end
            default: begin
              cal_wr_ofs  <= ~run_mode[0];
              cal_wr_gain <= run_mode[0];
              rdy_n       <= 1'b0;
              state       <= ST_IDLE;
              filt_rst    <= 1'b1;
              cal_busy    <= 1'b0;
              cal_system  <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({result_stb, cal_wr_ofs, cal_wr_gain})); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !cfg_wr) |=> !(result_stb || cal_wr_ofs || cal_wr_gain)); // R4

  AST_SLEEP_PWR: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> (!mod_run && filt_rst)); // R5

  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (result_stb && run_mode == M_SINGLE) |-> (pwr_down && !rdy_n)); // R6

  AST_CAL_RDY_HIGH: assert property (@(posedge clk) disable iff (rst)
    cal_busy |-> rdy_n); // R7

  AST_CAL_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cal_wr_ofs || cal_wr_gain) |-> (filt_rst && !cal_busy && !rdy_n && !pwr_down)); // R7

  AST_CAL_SYS_BUSY: assert property (@(posedge clk) disable iff (rst)
    cal_system |-> cal_busy); // R8

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    (conv_start && $past(cfg_wr)) |=> !filt_rst || !(state == ST_RUN)); // R13

endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int unsigned DIV_SHIFT = 0,
  parameter int          CH_W      = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_mode,
  input  logic [3:0]      cfg_rate,
  input  logic            cfg_chop_off,
  input  logic [CH_W-1:0] cfg_chan,
  input  logic [1:0]      cfg_clk_src,
  input  logic            rd_ack,
  output logic            filt_rst,
  output logic            conv_start,
  output logic            mod_run,
  output logic            pwr_down,
  output logic            result_stb,
  output logic            rdy_n,
  output logic            cal_busy,
  output logic            cal_system,
  output logic            cal_wr_ofs,
  output logic            cal_wr_gain,
  output logic [CH_W-1:0] cal_chan,
  output logic            osc_en,
  output logic            clk_pin_oe,
  output logic            ext_clk_sel
);

  logic             div_load;
  logic [CNT_W-1:0] div_val;
  logic             cnt_zero;

  conv_period_div #(.W(CNT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .load     (div_load),
    .load_val (div_val),
    .at_zero  (cnt_zero)
  );

  conv_mode_ctrl #(.DIV_SHIFT(DIV_SHIFT), .CH_W(CH_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr       (cfg_wr),
    .cfg_mode     (cfg_mode),
    .cfg_rate     (cfg_rate),
    .cfg_chop_off (cfg_chop_off),
    .cfg_chan     (cfg_chan),
    .rd_ack       (rd_ack),
    .cnt_zero     (cnt_zero),
    .div_load     (div_load),
    .div_val      (div_val),
    .filt_rst     (filt_rst),
    .conv_start   (conv_start),
    .mod_run      (mod_run),
    .pwr_down     (pwr_down),
    .result_stb   (result_stb),
    .rdy_n        (rdy_n),
    .cal_busy     (cal_busy),
    .cal_system   (cal_system),
    .cal_wr_ofs   (cal_wr_ofs),
    .cal_wr_gain  (cal_wr_gain),
    .cal_chan     (cal_chan)
  );

  conv_clk_route u_clk (
    .clk     (clk),
    .rst     (rst),
    .src     (cfg_clk_src),
    .osc_en  (osc_en),
    .pin_oe  (clk_pin_oe),
    .ext_sel (ext_clk_sel)
  );

endmodule

// File: tb/conv_seq_tb.sv
module conv_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SHIFT      = 8;
  localparam int PER_TAB [16] = '{4, 8, 16, 32, 64, 80, 102, 120,
                                  204, 240, 240, 320, 400, 480, 640, 960};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_mode = 3'b000;
  logic [3:0] cfg_rate = 4'b1010;
  logic       cfg_chop_off = 1'b0;
  logic [2:0] cfg_chan = 3'b000;
  logic [1:0] cfg_clk_src = 2'b00;
  logic       rd_ack = 1'b0;
  logic       filt_rst, conv_start, mod_run, pwr_down, result_stb, rdy_n;
  logic       cal_busy, cal_system, cal_wr_ofs, cal_wr_gain;
  logic [2:0] cal_chan;
  logic       osc_en, clk_pin_oe, ext_clk_sel;

  always #(CLK_PERIOD / 2) clk = ~clk;

  conv_seq #(.DIV_SHIFT(SHIFT), .CH_W(3)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_rate(cfg_rate),
    .cfg_chop_off(cfg_chop_off), .cfg_chan(cfg_chan), .cfg_clk_src(cfg_clk_src),
    .rd_ack(rd_ack), .filt_rst(filt_rst), .conv_start(conv_start), .mod_run(mod_run),
    .pwr_down(pwr_down), .result_stb(result_stb), .rdy_n(rdy_n), .cal_busy(cal_busy),
    .cal_system(cal_system), .cal_wr_ofs(cal_wr_ofs), .cal_wr_gain(cal_wr_gain),
    .cal_chan(cal_chan), .osc_en(osc_en), .clk_pin_oe(clk_pin_oe), .ext_clk_sel(ext_clk_sel)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    kind;   // 0 result, 1 offset store, 2 gain store
    int    at;
    int    chan;
    string req;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int at, input int chan, input string req);
    exp_t e;
    e.kind = kind; e.at = at; e.chan = chan; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: pops the scoreboard whenever a strobe appears
  always @(negedge clk) begin
    if (!rst && (result_stb || cal_wr_ofs || cal_wr_gain)) begin
      int k;
      k = result_stb ? 0 : (cal_wr_ofs ? 1 : 2);
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected strobe kind", k, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(k == e.kind, e.req, "strobe kind", k, e.kind);
        check(cyc == e.at, e.req, "strobe cycle", cyc, e.at);
        if (k != 0) check(int'(cal_chan) == e.chan, e.req, "cal channel", cal_chan, e.chan);
      end
    end
  end

  task automatic do_write(input logic [2:0] m, input logic [3:0] r, input logic co,
                          input logic [2:0] ch, output int w);
    cfg_mode = m; cfg_rate = r; cfg_chop_off = co; cfg_chan = ch;
    cfg_wr = 1'b1;
    w = cyc + 1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int w, w2, r0;
    repeat (4) @(negedge clk);
    // R12: reset state
    check(filt_rst == 1'b1, "R12", "filt_rst in reset", filt_rst, 1);
    check(rdy_n == 1'b1, "R12", "rdy_n in reset", rdy_n, 1);
    check(result_stb == 1'b0, "R12", "no strobe in reset", result_stb, 0);
    rst = 1'b0;
    r0 = cyc;
    // R12/R3/R1: default continuous, chop on, rate 1010
    push(0, r0 + 2 * PER_TAB[10], 0, "R12");
    push(0, r0 + 3 * PER_TAB[10], 0, "R1");
    wait_until(r0 + 3 * PER_TAB[10] + 1);
    check(rdy_n == 1'b0, "R10", "rdy_n after result", rdy_n, 0);
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    check(rdy_n == 1'b1, "R10", "rdy_n after rd_ack", rdy_n, 1);

    // R4: idle
    do_write(3'b010, 4'h0, 1'b0, 3'd0, w);
    wait_until(w + 300);
    check(filt_rst == 1'b1, "R4", "filt_rst idle", filt_rst, 1);
    check(mod_run == 1'b1, "R4", "mod_run idle", mod_run, 1);
    check(pwr_down == 1'b0, "R4", "pwr_down idle", pwr_down, 0);

    // R6/R3/R13: single from idle, chop on, rate 0000 -> 2P
    do_write(3'b001, 4'h0, 1'b0, 3'd0, w);
    check(conv_start == 1'b1 && filt_rst == 1'b1, "R13", "start pulse", conv_start, 1);
    @(negedge clk);
    check(filt_rst == 1'b0 && conv_start == 1'b0, "R13", "pulse one cycle", filt_rst, 0);
    push(0, w + 2 * PER_TAB[0], 0, "R3");
    wait_until(w + 2 * PER_TAB[0] + 1);
    check(pwr_down == 1'b1 && mod_run == 1'b0, "R6", "sleep after single", pwr_down, 1);
    wait_until(w + 80);
    check(rdy_n == 1'b0, "R6", "result held", rdy_n, 0);

    // R3: chop off continuous, rate 0101
    do_write(3'b000, 4'h5, 1'b1, 3'd0, w);
    push(0, w + PER_TAB[5], 0, "R3");
    push(0, w + 2 * PER_TAB[5], 0, "R1");
    wait_until(w + 2 * PER_TAB[5] + 1);
    // R5: sleep
    do_write(3'b011, 4'h5, 1'b1, 3'd0, w);
    wait_until(w + 200);
    check(pwr_down == 1'b1, "R5", "pwr_down", pwr_down, 1);
    check(mod_run == 1'b0, "R5", "mod_run", mod_run, 0);
    check(filt_rst == 1'b1, "R5", "filt_rst", filt_rst, 1);

    // R9: abort mid-conversion
    do_write(3'b000, 4'h3, 1'b0, 3'd0, w);
    wait_until(w + 20);
    do_write(3'b001, 4'h1, 1'b1, 3'd0, w2);
    push(0, w2 + PER_TAB[1], 0, "R9");
    wait_until(w + 2 * PER_TAB[3] + 40);

    // R7/R8: calibrations
    do_write(3'b100, 4'h2, 1'b0, 3'd1, w);
    check(cal_busy == 1'b1 && rdy_n == 1'b1, "R7", "cal busy, rdy high", rdy_n, 1);
    check(cal_system == 1'b0, "R8", "internal cal", cal_system, 0);
    push(1, w + 2 * PER_TAB[2], 1, "R7");
    wait_until(w + 2 * PER_TAB[2] + 1);
    check(rdy_n == 1'b0 && cal_busy == 1'b0, "R7", "cal end rdy low", rdy_n, 0);
    check(filt_rst == 1'b1 && pwr_down == 1'b0, "R7", "idle after cal", filt_rst, 1);
    wait_until(w + 150);

    do_write(3'b111, 4'h2, 1'b1, 3'd0, w);
    check(cal_system == 1'b1, "R8", "system cal", cal_system, 1);
    push(2, w + PER_TAB[2], 0, "R7");
    wait_until(w + PER_TAB[2] + 5);

    do_write(3'b101, 4'h1, 1'b1, 3'd3, w);
    check(cal_system == 1'b0, "R8", "internal fs cal", cal_system, 0);
    push(2, w + PER_TAB[1], 3, "R7");
    wait_until(w + PER_TAB[1] + 5);

    do_write(3'b110, 4'h1, 1'b1, 3'd5, w);
    check(cal_system == 1'b1, "R8", "system zs cal", cal_system, 1);
    push(1, w + PER_TAB[1], 5, "R7");
    wait_until(w + PER_TAB[1] + 5);

    // R2: sweep all rate codes with single, chop off
    for (int c = 0; c < 16; c++) begin
      do_write(3'b001, 4'(c), 1'b1, 3'd0, w);
      push(0, w + PER_TAB[c], 0, "R2");
      wait_until(w + PER_TAB[c] + 2);
    end

    // R11: clock routing
    for (int s = 0; s < 4; s++) begin
      cfg_clk_src = 2'(s);
      @(negedge clk); @(negedge clk);
      check(osc_en == (s < 2), "R11", "osc_en", osc_en, s < 2);
      check(clk_pin_oe == (s == 1), "R11", "clk_pin_oe", clk_pin_oe, s == 1);
      check(ext_clk_sel == (s >= 2), "R11", "ext_clk_sel", ext_clk_sel, s >= 2);
    end

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R1", "pending expected strobes", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule